// File: doc/BRIEF.md
# Bit Manipulate and Skip Unit

This block carries out the single-bit instructions of a small controller core that has no flag-based conditional branches. Each issued instruction comes with the value read from the addressed register, a bit number and an opcode class. A set or clear instruction produces a read-modify-write result in which only the selected bit differs, together with a write enable. A test instruction examines the selected bit of any register, including the one that holds the ALU status flags. When its condition holds, it asks fetch to drop the next instruction.

The unit also holds the skip state. A two-state machine holds `ST_RUN` while instructions execute normally. The transition `ARM_SKIP` moves it to `ST_SHADOW` when an executed test instruction meets its condition. The transition `CONSUME` takes it back to `ST_RUN` on the next issued instruction, which is squashed: it writes nothing and tests nothing. A squashed test instruction therefore cannot start a new skip. Idle cycles with no instruction issued leave the state where it is. Register storage sits outside the block.

Top module: `bit_skip_unit`

## Requirements
- R1: During and after reset the machine is in `ST_RUN`: with nothing issued, `wr_en`, `skip_req` and `squash` are all 0, and the first instruction after reset executes normally, even if a skip was pending when reset was applied.
- R2: Opcode 3'd1 (set) drives `wr_en`=1 and `wr_data` = `rd_data` with bit `bit_idx` forced to 1, in the same cycle the instruction is issued.
- R3: Opcode 3'd2 (clear) drives `wr_en`=1 and `wr_data` = `rd_data` with bit `bit_idx` forced to 0.
- R4: `bit_idx` value k selects bit k (bit 0 is the LSB) for every k from 0 to 7, and set or clear never changes any other bit.
- R5: Opcode 3'd3 (skip if set) raises `skip_req` exactly when the selected bit of `rd_data` is 1, and never raises `wr_en`.
- R6: Opcode 3'd4 (skip if clear) raises `skip_req` exactly when the selected bit of `rd_data` is 0, and never raises `wr_en`.
- R7: After a cycle with `skip_req`=1, the next cycle with `instr_valid`=1 shows `squash`=1, `wr_en`=0 and `skip_req`=0, whatever its opcode. Cycles with `instr_valid`=0 in between do not use up the pending skip.
- R8: A squashed skip instruction does not request a skip, even when its condition holds, so the instruction after it executes.
- R9: A skip suppresses exactly one instruction: the second issued instruction after `skip_req` executes normally.
- R10: Opcodes 0, 5, 6 and 7 are not bit instructions: they drive `wr_en`=0 and `skip_req`=0, and leave the machine in `ST_RUN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction is issued this cycle |
| op | input | 3 | Opcode class (0 other, 1 set, 2 clear, 3 skip if set, 4 skip if clear) |
| bit_idx | input | 3 | Bit number within the register |
| rd_data | input | 8 | Current value of the addressed register |
| wr_data | output | 8 | Write-back value |
| wr_en | output | 1 | Write-back enable |
| skip_req | output | 1 | Tells fetch that the next instruction is to be dropped |
| squash | output | 1 | The instruction issued this cycle is squashed |

## Verification
The bench places idle gaps between a skip and the instruction it hides. A design that cleared the pending skip on any cycle would let the hidden instruction write. It chains a skip behind a skip whose own condition holds. A design that still tested squashed instructions would drop two instructions instead of one. It walks every bit index with set and clear on all-zero and all-one registers, which exposes a mask that is shifted or that changes a neighbour bit. It also asserts reset while a skip is pending. A state register without proper reset would then squash the first instruction afterwards.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

    typedef enum logic [2:0] {
        OP_OTHER    = 3'd0,
        OP_SET      = 3'd1,
        OP_CLR      = 3'd2,
        OP_SKIP_SET = 3'd3,
        OP_SKIP_CLR = 3'd4
    } bsu_op_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_SHADOW = 1'b1
    } bsu_state_e;

endpackage

// File: rtl/bsu_bit_mask.sv
module bsu_bit_mask #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] mask
);

    for (genvar g = 0; g < DATA_W; g++) begin : g_dec
        assign mask[g] = (idx == IDX_W'(g));
    end

endmodule

// File: rtl/bsu_bit_alu.sv
module bsu_bit_alu #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] mask,
    input  logic              do_set,
    input  logic              do_clr,
    output logic [DATA_W-1:0] new_data,
    output logic              bit_val
);

    always_comb begin
        new_data = rd_data;
        if (do_set) begin
            new_data = rd_data | mask;
        end else if (do_clr) begin
            new_data = rd_data & ~mask;
        end
        bit_val = |(rd_data & mask);
    end

endmodule

// File: rtl/bsu_skip_fsm.sv
module bsu_skip_fsm
    import bsu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic is_test,
    input  logic cond_met,
    output logic squash,
    output logic fire
);

    bsu_state_e state_q;
    bsu_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions ARM_SKIP and CONSUME
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (issue && is_test && cond_met) begin
                    state_d = ST_SHADOW;
                end
            end
            ST_SHADOW: begin
                if (issue) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        squash = 1'b0;
        fire   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                fire = issue && is_test && cond_met;
            end
            ST_SHADOW: begin
                squash = issue;
            end
            default: begin
                squash = 1'b0;
                fire   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bit_skip_unit.sv
module bit_skip_unit
    import bsu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W),
    parameter int OP_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [OP_W-1:0]   op,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_en,
    output logic              skip_req,
    output logic              squash
);

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] new_data;
    logic              bit_val;
    logic              is_set;
    logic              is_clr;
    logic              is_sks;
    logic              is_skc;
    logic              cond_met;
    logic              fire;
    logic              sq;

    always_comb begin
        is_set = (op == OP_W'(OP_SET));
        is_clr = (op == OP_W'(OP_CLR));
        is_sks = (op == OP_W'(OP_SKIP_SET));
        is_skc = (op == OP_W'(OP_SKIP_CLR));
        cond_met = is_sks ? bit_val : !bit_val;
    end

    bsu_bit_mask #(.DATA_W(DATA_W), .IDX_W(IDX_W)) mask_i (
        .idx  (bit_idx),
        .mask (mask)
    );

    bsu_bit_alu #(.DATA_W(DATA_W)) alu_i (
        .rd_data  (rd_data),
        .mask     (mask),
        .do_set   (is_set),
        .do_clr   (is_clr),
        .new_data (new_data),
        .bit_val  (bit_val)
    );

    bsu_skip_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (instr_valid),
        .is_test  (is_sks || is_skc),
        .cond_met (cond_met),
        .squash   (sq),
        .fire     (fire)
    );

    always_comb begin
        squash   = sq;
        skip_req = fire;
        wr_en    = instr_valid && !sq && (is_set || is_clr);
        wr_data  = new_data;
    end

endmodule

// File: rtl/bsu_checker.sv
module bsu_checker #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W),
    parameter int OP_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [OP_W-1:0]   op,
    input logic [IDX_W-1:0]  bit_idx,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_en,
    input logic              skip_req,
    input logic              squash
);

    logic pending_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else if (skip_req) begin
            pending_q <= 1'b1;
        end else if (instr_valid) begin
            pending_q <= 1'b0;
        end
    end

    // R7, R9: squash tracks the pending skip exactly
    p_squash_follows_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |-> (squash == pending_q));

    // R7: squashed instruction has no effect
    p_squash_inert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> (!wr_en && !skip_req));

    // R8: squash never coexists with a new request
    p_no_chain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pending_q |-> !skip_req);

    // R4: at most the selected bit changes
    p_one_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($countones(wr_data ^ rd_data) <= 1));

    // R2: set leaves selected bit high
    p_set_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_W'(1)) |-> wr_data[bit_idx]);

    // R3: clear leaves selected bit low
    p_clr_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_W'(2)) |-> !wr_data[bit_idx]);

    // R5, R6: tests never write
    p_test_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_W'(3) || op == OP_W'(4)) |-> !wr_en);

    // R10: only test opcodes request skips
    p_skip_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |-> (instr_valid && (op == OP_W'(3) || op == OP_W'(4))));

endmodule

bind bit_skip_unit bsu_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W), .OP_W(OP_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .op          (op),
    .bit_idx     (bit_idx),
    .rd_data     (rd_data),
    .wr_data     (wr_data),
    .wr_en       (wr_en),
    .skip_req    (skip_req),
    .squash      (squash)
);

// File: tb/bit_skip_unit_tb_top.sv
`timescale 1ns/1ps
module bit_skip_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_valid = 1'b0;
    logic [2:0] op = 3'd0;
    logic [2:0] bit_idx = 3'd0;
    logic [7:0] rd_data = 8'h00;
    logic [7:0] wr_data;
    logic       wr_en;
    logic       skip_req;
    logic       squash;

    always #4 clk = ~clk;

    bit_skip_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .op          (op),
        .bit_idx     (bit_idx),
        .rd_data     (rd_data),
        .wr_data     (wr_data),
        .wr_en       (wr_en),
        .skip_req    (skip_req),
        .squash      (squash)
    );

    typedef struct {
        logic       we;
        logic [7:0] wd;
        logic       sk;
        logic       sq;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    logic model_pending = 1'b0;

    // monitor
    always begin
        @(negedge clk);
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (wr_en !== e.we || skip_req !== e.sk || squash !== e.sq ||
                (e.we && wr_data !== e.wd)) begin
                failures++;
                $display("FAIL %s: act we=%b wd=%h sk=%b sq=%b exp we=%b wd=%h sk=%b sq=%b",
                         e.tag, wr_en, wr_data, skip_req, squash, e.we, e.wd, e.sk, e.sq);
            end
        end
    end

    task automatic issue(input logic v, input logic [2:0] o, input int idx,
                         input logic [7:0] d, input string tag);
        exp_t e;
        logic b;
        @(negedge clk);
        instr_valid = v;
        op          = o;
        bit_idx     = idx[2:0];
        rd_data     = d;
        b    = d[idx];
        e.we = 1'b0; e.wd = d; e.sk = 1'b0; e.sq = 1'b0; e.tag = tag;
        if (v && model_pending) begin
            e.sq = 1'b1;
            model_pending = 1'b0;
        end else if (v) begin
            case (o)
                3'd1: begin e.we = 1'b1; e.wd = d | (8'h01 << idx); end
                3'd2: begin e.we = 1'b1; e.wd = d & ~(8'h01 << idx); end
                3'd3: e.sk = b;
                3'd4: e.sk = !b;
                default: ;
            endcase
            model_pending = e.sk;
        end
        q.push_back(e);
    endtask

    task automatic pulse_reset(input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = 1'b0;
        instr_valid = 1'b0;
        model_pending = 1'b0;
        e.we = 1'b0; e.wd = 8'h00; e.sk = 1'b0; e.sq = 1'b0; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        pulse_reset("R1 reset outputs idle");
        pulse_reset("R1 reset outputs idle");
        issue(1, 3'd1, 0, 8'h00, "R1 first instr executes / R2 set");
        issue(1, 3'd1, 3, 8'hF7, "R2 set bit3");
        issue(1, 3'd1, 5, 8'hFF, "R2 set already set");
        issue(1, 3'd2, 7, 8'hFF, "R3 clear bit7");
        issue(1, 3'd2, 4, 8'h00, "R3 clear already clear");
        for (int i = 0; i < 8; i++) begin
            issue(1, 3'd1, i, 8'h00, "R4 set walk");
            issue(1, 3'd2, i, 8'hFF, "R4 clear walk");
        end
        issue(1, 3'd3, 2, 8'h04, "R5 skip-if-set taken");
        issue(1, 3'd1, 0, 8'h00, "R7 squashed set");
        issue(1, 3'd1, 1, 8'h00, "R9 second after skip executes");
        issue(1, 3'd3, 2, 8'hFB, "R5 skip-if-set not taken");
        issue(1, 3'd2, 0, 8'hFF, "R5 next executes");
        issue(1, 3'd4, 6, 8'h00, "R6 skip-if-clear taken");
        issue(0, 3'd2, 0, 8'hFF, "R7 idle keeps pending");
        issue(0, 3'd1, 0, 8'h00, "R7 idle keeps pending");
        issue(1, 3'd2, 0, 8'hFF, "R7 squashed clear after idle");
        issue(1, 3'd2, 1, 8'hFF, "R9 executes after squash");
        issue(1, 3'd4, 6, 8'h40, "R6 skip-if-clear not taken");
        issue(1, 3'd3, 0, 8'h01, "R8 arm skip");
        issue(1, 3'd3, 0, 8'h01, "R8 squashed skip does not test");
        issue(1, 3'd1, 2, 8'h00, "R8 instr after squashed skip executes");
        issue(1, 3'd0, 0, 8'h00, "R10 other op inert");
        issue(1, 3'd7, 3, 8'hFF, "R10 undefined op inert");
        issue(1, 3'd1, 6, 8'h00, "R10 machine still running");
        issue(1, 3'd4, 1, 8'h00, "R6 arm skip");
        issue(1, 3'd0, 0, 8'h00, "R7 other op squashed");
        issue(1, 3'd3, 7, 8'h80, "R1 arm before reset");
        pulse_reset("R1 reset clears pending");
        issue(1, 3'd1, 4, 8'h00, "R1 executes after reset");
        issue(0, 3'd0, 0, 8'h00, "R1 idle");
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: act hung exp done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule